// File: doc/BRIEF.md
# Flash Command Decoder

This block turns bus writes aimed at a parallel flash into command strobes. Each accepted write carries an address and a data word. The block follows the multi-write unlock handshakes and recognises seven commands: read/reset, auto-select, program, chip erase, block erase, erase suspend and erase resume. For each command it raises a strobe for one clock. For program and block erase it also presents the address and data of the write that completed the command.

The block keeps a register that holds the current operating mode. It uses this mode to drop any command that the running operation does not allow. The erase/program engine reports back through `ctl_done` and `ctl_fail`. The engine, the array and the bus electrical timing sit outside the block.

The write interface uses valid/ready. `wr_ready` is held high, so the block never applies back-pressure: every cycle with `wr_valid` high is one bus write. Every other pin is a plain level or pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Unlock matching depends on `byte_mode`.
  - When `byte_mode`=0 (word), the first unlock write is AAh at `wr_addr[10:0]`=555h and the second is 55h at `wr_addr[10:0]`=2AAh.
  - When `byte_mode`=1, the first unlock write is AAh at `wr_addr[11:0]`=AAAh and the second is 55h at `wr_addr[11:0]`=555h.
  - Address bits above those and `wr_data[15:8]` are never compared.
- R2: Read/reset is either a lone write of F0h to any address, or the two unlock writes followed by F0h to any address. It pulses `cmd_reset`.
- R3: Auto-select is the two unlock writes followed by 90h at the first unlock address. It pulses `cmd_autosel`, and `mode_state` becomes 1.
- R4: Program is the two unlock writes, then A0h at the first unlock address, then one more write with any address and data.
  - It pulses `cmd_program`.
  - `cmd_addr` and `cmd_data` then equal the fourth write.
  - `mode_state` becomes 2.
- R5: Chip erase is six writes: unlock, 80h at the first unlock address, unlock, then 10h at the first unlock address. It pulses `cmd_chip_erase`, and `mode_state` becomes 3.
- R6: Block erase is the same six writes except that the last one is 30h at any address.
  - It pulses `cmd_block_erase` with `cmd_addr` set to that address, and `mode_state` becomes 4 (collecting).
  - While collecting, each lone 30h write adds another block, pulses `cmd_block_erase` again and restarts the window.
  - After WINDOW+1 cycles with no added block, `mode_state` becomes 5 (erasing).
- R7: A write that does not continue a valid sequence returns the sequence position to zero without a strobe. From mode 0 or 1 the mode becomes 0; from mode 7 it becomes 6.
- R8: In mode 2 (program) or mode 3 (chip erase), every write is ignored. When `ctl_done` arrives with `ctl_fail` low, the mode becomes 0.
- R9: Only erase suspend (a lone B0h, which pulses `cmd_suspend` and sets mode 6) and read/reset (which sets mode 0) are accepted in these modes:
  - mode 4 (collecting), apart from the added blocks of R6;
  - mode 5 (erasing).
  In mode 0, a lone B0h is ignored.
- R10: In mode 6 (suspended):
  - A lone 30h pulses `cmd_resume` and sets mode 5.
  - Read/reset pulses `cmd_reset` and the mode stays 6.
  - A program command sets mode 8; `ctl_done` then returns the mode to 6.
  - A second B0h is ignored.
- R11: When `ctl_done` arrives with `ctl_fail` high in mode 2, 3, 5 or 8, the mode becomes 9 (error). In mode 9 only read/reset has an effect: it pulses `cmd_reset` and sets mode 0.
- R12: Timing of strobes and reset:
  - A strobe rises in the cycle after the clock edge that took the write, and lasts exactly one cycle.
  - At most one strobe is high at a time.
  - Synchronous reset clears all strobes, sets mode 0 and sets the sequence position to zero.
- R13: `wr_ready` is always 1. The sequence position moves only on cycles with `wr_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| wr_valid | input | 1 | A bus write is offered |
| wr_ready | output | 1 | Always 1; no back-pressure |
| wr_addr | input | ADDR_W | Write address (bit 0 is the lowest bus address bit of the active mode) |
| wr_data | input | DATA_W | Write data |
| ctl_done | input | 1 | Engine finished the current operation (pulse) |
| ctl_fail | input | 1 | Qualifies `ctl_done` as a failure |
| cmd_reset | output | 1 | Read/reset strobe |
| cmd_autosel | output | 1 | Auto-select strobe |
| cmd_program | output | 1 | Program strobe |
| cmd_chip_erase | output | 1 | Chip erase strobe |
| cmd_block_erase | output | 1 | Block erase strobe (once per block) |
| cmd_suspend | output | 1 | Erase suspend strobe |
| cmd_resume | output | 1 | Erase resume strobe |
| cmd_addr | output | ADDR_W | Address of the write that raised the last strobe |
| cmd_data | output | DATA_W | Data of the write that raised the last strobe |
| mode_state | output | 4 | Current mode, encoded 0 to 9 as in R3 to R11 |

## Verification
The embedded properties check, on every cycle, the following:
- the strobes are mutually exclusive, and each one follows a decoded event;
- program, chip erase and suspended-program modes stay silent;
- the erasing mode passes only suspend or reset, and the error mode passes only reset;
- the sequence position stays in range and holds between writes;
- the window counter stays bounded, and a failed completion always lands in the error mode.

The bench scenarios are the only way to show the byte/word address matching, the don't-care bits, the exact address and data carried by program and block erase, and the collecting window expiring into the erasing mode. They also show the full suspend/program/resume round trip and a reset that lands in the middle of a sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    M_READ      = 4'd0,
    M_AUTOSEL   = 4'd1,
    M_PROG      = 4'd2,
    M_CHIP      = 4'd3,
    M_BCOLLECT  = 4'd4,
    M_BERASE    = 4'd5,
    M_SUSP      = 4'd6,
    M_SUSP_AS   = 4'd7,
    M_SUSP_PROG = 4'd8,
    M_ERROR     = 4'd9
  } mode_t;

  typedef enum logic [3:0] {
    EV_NONE,
    EV_ABORT,
    EV_RESET,
    EV_AUTOSEL,
    EV_PROG,
    EV_CHIP,
    EV_BLK,
    EV_SUSP,
    EV_LONE30
  } ev_t;

  localparam logic [7:0] OP_UL1   = 8'hAA;
  localparam logic [7:0] OP_UL2   = 8'h55;
  localparam logic [7:0] OP_RESET = 8'hF0;
  localparam logic [7:0] OP_ASEL  = 8'h90;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_ERASE = 8'h80;
  localparam logic [7:0] OP_CHIP  = 8'h10;
  localparam logic [7:0] OP_BLK   = 8'h30;
  localparam logic [7:0] OP_SUSP  = 8'hB0;

  localparam int NSTB    = 7;
  localparam int S_RESET = 0;
  localparam int S_ASEL  = 1;
  localparam int S_PROG  = 2;
  localparam int S_CHIP  = 3;
  localparam int S_BLK   = 4;
  localparam int S_SUSP  = 5;
  localparam int S_RES   = 6;

endpackage

// File: rtl/fcd_match.sv
module fcd_match (
  input  logic        byte_mode,
  input  logic [11:0] addr_lo,
  output logic        is_ul1,
  output logic        is_ul2
);
  // Unlock addresses: word mode compares 11 bits, byte mode adds the sub-word bit.
  localparam logic [10:0] W_UL1 = 11'h555;
  localparam logic [10:0] W_UL2 = 11'h2AA;
  localparam logic [11:0] B_UL1 = 12'hAAA;
  localparam logic [11:0] B_UL2 = 12'h555;

  always_comb begin
    if (byte_mode) begin
      is_ul1 = (addr_lo == B_UL1);
      is_ul2 = (addr_lo == B_UL2);
    end else begin
      is_ul1 = (addr_lo[10:0] == W_UL1);
      is_ul2 = (addr_lo[10:0] == W_UL2);
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       wr_valid,
  input  logic       is_ul1,
  input  logic       is_ul2,
  input  logic [7:0] code,
  output ev_t        ev
);
  localparam int POS_W   = 3;
  localparam int POS_MAX = 5;

  logic [POS_W-1:0] pos_q, pos_n;
  logic [7:0]       op_q, op_n;

  always_comb begin
    ev    = EV_NONE;
    pos_n = pos_q;
    op_n  = op_q;
    if (clr) begin
      pos_n = '0;
    end else if (wr_valid) begin
      case (pos_q)
        3'd0: begin
          if (code == OP_UL1 && is_ul1) pos_n = 3'd1;
          else if (code == OP_RESET)    ev = EV_RESET;
          else if (code == OP_SUSP)     ev = EV_SUSP;
          else if (code == OP_BLK)      ev = EV_LONE30;
          else                          ev = EV_ABORT;
        end
        3'd1, 3'd4: begin
          if (code == OP_UL2 && is_ul2) pos_n = pos_q + 3'd1;
          else begin
            pos_n = '0;
            ev    = EV_ABORT;
          end
        end
        3'd2: begin
          pos_n = '0;
          if (code == OP_RESET) ev = EV_RESET;
          else if (is_ul1 && code == OP_ASEL) ev = EV_AUTOSEL;
          else if (is_ul1 && (code == OP_PROG || code == OP_ERASE)) begin
            pos_n = 3'd3;
            op_n  = code;
          end else ev = EV_ABORT;
        end
        3'd3: begin
          pos_n = '0;
          if (op_q == OP_PROG) ev = EV_PROG;
          else if (code == OP_UL1 && is_ul1) pos_n = 3'd4;
          else ev = EV_ABORT;
        end
        3'd5: begin
          pos_n = '0;
          if (is_ul1 && code == OP_CHIP) ev = EV_CHIP;
          else if (code == OP_BLK)       ev = EV_BLK;
          else                           ev = EV_ABORT;
        end
        default: begin
          pos_n = '0;
          ev    = EV_ABORT;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      op_q  <= '0;
    end else begin
      pos_q <= pos_n;
      op_q  <= op_n;
    end
  end

  assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
    pos_q <= 3'(POS_MAX));

  assert_pos_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && !clr) |=> $stable(pos_q));

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WINDOW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_t               ev_in,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_done,
  input  logic              ctl_fail,
  output mode_t             mode_q,
  output logic [NSTB-1:0]   stb_q,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              seq_clr
);
  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW);

  mode_t            mode_n;
  logic [NSTB-1:0]  stb_n;
  logic [WIN_W-1:0] win_q, win_n;

  always_comb begin
    mode_n = mode_q;
    stb_n  = '0;
    win_n  = win_q;
    case (mode_q)
      M_READ, M_AUTOSEL: begin
        case (ev_in)
          EV_RESET:   begin stb_n[S_RESET] = 1'b1; mode_n = M_READ;    end
          EV_AUTOSEL: begin stb_n[S_ASEL]  = 1'b1; mode_n = M_AUTOSEL; end
          EV_PROG:    begin stb_n[S_PROG]  = 1'b1; mode_n = M_PROG;    end
          EV_CHIP:    begin stb_n[S_CHIP]  = 1'b1; mode_n = M_CHIP;    end
          EV_BLK: begin
            stb_n[S_BLK] = 1'b1;
            mode_n       = M_BCOLLECT;
            win_n        = WIN_LOAD;
          end
          EV_ABORT:   mode_n = M_READ;
          default:    ;
        endcase
      end
      M_PROG, M_CHIP: begin
        if (ctl_done) mode_n = ctl_fail ? M_ERROR : M_READ;
      end
      M_BCOLLECT: begin
        if (ev_in == EV_BLK || ev_in == EV_LONE30) begin
          stb_n[S_BLK] = 1'b1;
          win_n        = WIN_LOAD;
        end else if (ev_in == EV_SUSP) begin
          stb_n[S_SUSP] = 1'b1;
          mode_n        = M_SUSP;
        end else if (ev_in == EV_RESET) begin
          stb_n[S_RESET] = 1'b1;
          mode_n         = M_READ;
        end else if (win_q == '0) begin
          mode_n = M_BERASE;
        end else begin
          win_n = win_q - 1'b1;
        end
      end
      M_BERASE: begin
        if (ctl_done) mode_n = ctl_fail ? M_ERROR : M_READ;
        else if (ev_in == EV_SUSP) begin
          stb_n[S_SUSP] = 1'b1;
          mode_n        = M_SUSP;
        end else if (ev_in == EV_RESET) begin
          stb_n[S_RESET] = 1'b1;
          mode_n         = M_READ;
        end
      end
      M_SUSP, M_SUSP_AS: begin
        case (ev_in)
          EV_LONE30: if (mode_q == M_SUSP) begin
            stb_n[S_RES] = 1'b1;
            mode_n       = M_BERASE;
          end
          EV_RESET:   begin stb_n[S_RESET] = 1'b1; mode_n = M_SUSP;      end
          EV_AUTOSEL: begin stb_n[S_ASEL]  = 1'b1; mode_n = M_SUSP_AS;   end
          EV_PROG:    begin stb_n[S_PROG]  = 1'b1; mode_n = M_SUSP_PROG; end
          EV_ABORT:   mode_n = M_SUSP;
          default:    ;
        endcase
      end
      M_SUSP_PROG: begin
        if (ctl_done) mode_n = ctl_fail ? M_ERROR : M_SUSP;
      end
      M_ERROR: begin
        if (ev_in == EV_RESET) begin
          stb_n[S_RESET] = 1'b1;
          mode_n         = M_READ;
        end
      end
      default: mode_n = M_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_READ;
      stb_q    <= '0;
      win_q    <= '0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      mode_q <= mode_n;
      stb_q  <= stb_n;
      win_q  <= win_n;
      if (stb_n != '0) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end

  assign seq_clr = (mode_q == M_PROG) || (mode_q == M_CHIP) || (mode_q == M_SUSP_PROG);

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q));

  assert_strobe_cause_R12: assert property (@(posedge clk) disable iff (rst)
    (ev_in == EV_NONE || ev_in == EV_ABORT) |=> (stb_q == '0));

  assert_busy_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PROG || mode_q == M_CHIP || mode_q == M_SUSP_PROG) |=> (stb_q == '0));

  assert_erase_filter_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_BERASE) |=> (stb_q == '0 || stb_q[S_SUSP] || stb_q[S_RESET]));

  assert_error_reset_only_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ERROR) |=> (stb_q == '0 || stb_q[S_RESET]));

  assert_fail_enters_error_R11: assert property (@(posedge clk) disable iff (rst)
    (ctl_done && ctl_fail && (mode_q == M_PROG || mode_q == M_CHIP ||
     mode_q == M_BERASE || mode_q == M_SUSP_PROG)) |=> (mode_q == M_ERROR));

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
    win_q <= WIN_LOAD);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WINDOW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_done,
  input  logic              ctl_fail,
  output logic              cmd_reset,
  output logic              cmd_autosel,
  output logic              cmd_program,
  output logic              cmd_chip_erase,
  output logic              cmd_block_erase,
  output logic              cmd_suspend,
  output logic              cmd_resume,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [3:0]        mode_state
);
  ev_t             ev;
  logic            ul1, ul2, clr;
  mode_t           mode;
  logic [NSTB-1:0] stb;

  assign wr_ready = 1'b1;

  fcd_match u_match (
    .byte_mode (byte_mode),
    .addr_lo   (wr_addr[11:0]),
    .is_ul1    (ul1),
    .is_ul2    (ul2)
  );

  fcd_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .wr_valid (wr_valid),
    .is_ul1   (ul1),
    .is_ul2   (ul2),
    .code     (wr_data[7:0]),
    .ev       (ev)
  );

  fcd_mode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WINDOW (WINDOW)
  ) u_mode (
    .clk      (clk),
    .rst      (rst),
    .ev_in    (ev),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctl_done (ctl_done),
    .ctl_fail (ctl_fail),
    .mode_q   (mode),
    .stb_q    (stb),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .seq_clr  (clr)
  );

  assign cmd_reset       = stb[S_RESET];
  assign cmd_autosel     = stb[S_ASEL];
  assign cmd_program     = stb[S_PROG];
  assign cmd_chip_erase  = stb[S_CHIP];
  assign cmd_block_erase = stb[S_BLK];
  assign cmd_suspend     = stb[S_SUSP];
  assign cmd_resume      = stb[S_RES];
  assign mode_state      = mode;

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int WINDOW = 32;
  localparam int NV     = 18;

  logic clk = 1'b0;
  logic rst, byte_mode, wr_valid, ctl_done, ctl_fail;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic wr_ready;
  logic c_rst, c_asel, c_prog, c_chip, c_blk, c_susp, c_res;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic [3:0] mode_state;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW(WINDOW)) u_dut (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_done(ctl_done), .ctl_fail(ctl_fail),
    .cmd_reset(c_rst), .cmd_autosel(c_asel), .cmd_program(c_prog),
    .cmd_chip_erase(c_chip), .cmd_block_erase(c_blk), .cmd_suspend(c_susp),
    .cmd_resume(c_res), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .mode_state(mode_state)
  );

  // Vector: {byte_mode, addr, data, expected strobe code, expected mode}
  // Strobe codes: 0 none, 1 reset, 2 autosel, 3 program, 4 chip, 5 block, 6 suspend, 7 resume
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 20'h00123, 16'h00F0, 4'd1, 4'd0},  // R2 lone F0
    {1'b0, 20'h00555, 16'h00AA, 4'd0, 4'd0},
    {1'b0, 20'h002AA, 16'h0055, 4'd0, 4'd0},
    {1'b0, 20'h00555, 16'h0090, 4'd2, 4'd1},  // R3
    {1'b0, 20'h00555, 16'h00AA, 4'd0, 4'd1},
    {1'b0, 20'h002AA, 16'h0055, 4'd0, 4'd1},
    {1'b0, 20'h00000, 16'h00F0, 4'd1, 4'd0},  // R2 three-write form
    {1'b1, 20'h00AAA, 16'h00AA, 4'd0, 4'd0},  // R1 byte mode
    {1'b1, 20'h00555, 16'h0055, 4'd0, 4'd0},
    {1'b1, 20'h00AAA, 16'h0090, 4'd2, 4'd1},
    {1'b1, 20'h00555, 16'h00AA, 4'd0, 4'd0},  // R7 word address in byte mode breaks
    {1'b0, 20'h7F555, 16'h12AA, 4'd0, 4'd0},  // R1 high bits don't care
    {1'b0, 20'h3F2AA, 16'hFF55, 4'd0, 4'd0},
    {1'b0, 20'h80555, 16'h0090, 4'd2, 4'd1},
    {1'b0, 20'h00555, 16'h00AA, 4'd0, 4'd1},
    {1'b0, 20'h002AA, 16'h0055, 4'd0, 4'd1},
    {1'b0, 20'h00555, 16'h0077, 4'd0, 4'd0},  // R7 bad opcode
    {1'b0, 20'h00000, 16'h00B0, 4'd0, 4'd0}   // R9 suspend ignored in read mode
  };

  function automatic logic [3:0] stb_code();
    logic [6:0] v;
    v = {c_res, c_susp, c_blk, c_chip, c_prog, c_asel, c_rst};
    if ($countones(v) == 0) return 4'd0;
    if ($countones(v) > 1) return 4'hF;
    for (int i = 0; i < 7; i++) if (v[i]) return 4'(i + 1);
    return 4'hF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bm, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    byte_mode = bm; wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [3:0] code, input logic [3:0] mode);
    chk({req, " strobe"}, 32'(stb_code()), 32'(code));
    chk({req, " mode"}, 32'(mode_state), 32'(mode));
  endtask

  task automatic done_pulse(input logic fail);
    @(negedge clk);
    ctl_done = 1'b1; ctl_fail = fail;
    @(negedge clk);
    ctl_done = 1'b0; ctl_fail = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; byte_mode = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    ctl_done = 1'b0; ctl_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R12 reset", 4'd0, 4'd0);
    chk("R13 ready", 32'(wr_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][44], VEC[i][43:24], VEC[i][23:8]);
      expect_out("R1 R2 R3 R7 R9 table", VEC[i][7:4], VEC[i][3:0]);
    end

    // R4 program, R8 busy, R12 one-cycle strobe
    wr(0, 20'h00555, 16'h00AA); wr(0, 20'h002AA, 16'h0055); wr(0, 20'h00555, 16'h00A0);
    wr(0, 20'h4ABCD, 16'h1234);
    expect_out("R4 program", 4'd3, 4'd2);
    chk("R4 addr", 32'(cmd_addr), 32'h4ABCD);
    chk("R4 data", 32'(cmd_data), 32'h1234);
    @(negedge clk);
    chk("R12 strobe width", 32'(stb_code()), 32'd0);
    wr(0, 20'h00000, 16'h00F0);
    expect_out("R8 ignore during program", 4'd0, 4'd2);
    done_pulse(1'b0);
    chk("R8 done to read", 32'(mode_state), 32'd0);

    // R5 chip erase in byte mode, R11 error
    wr(1, 20'h00AAA, 16'h00AA); wr(1, 20'h00555, 16'h0055); wr(1, 20'h00AAA, 16'h0080);
    wr(1, 20'h00AAA, 16'h00AA); wr(1, 20'h00555, 16'h0055); wr(1, 20'h00AAA, 16'h0010);
    expect_out("R5 chip erase", 4'd4, 4'd3);
    done_pulse(1'b1);
    chk("R11 fail to error", 32'(mode_state), 32'd9);
    wr(0, 20'h00100, 16'h0090);
    expect_out("R11 error ignores", 4'd0, 4'd9);
    wr(0, 20'h00000, 16'h00F0);
    expect_out("R11 reset clears error", 4'd1, 4'd0);

    // R6 block erase with extra block and window
    wr(0, 20'h00555, 16'h00AA); wr(0, 20'h002AA, 16'h0055); wr(0, 20'h00555, 16'h0080);
    wr(0, 20'h00555, 16'h00AA); wr(0, 20'h002AA, 16'h0055); wr(0, 20'h12345, 16'h0030);
    expect_out("R6 block erase", 4'd5, 4'd4);
    chk("R6 block addr", 32'(cmd_addr), 32'h12345);
    wr(0, 20'h22000, 16'h0030);
    expect_out("R6 added block", 4'd5, 4'd4);
    chk("R6 added addr", 32'(cmd_addr), 32'h22000);
    wr(0, 20'h00000, 16'h0090);
    expect_out("R9 collect ignores", 4'd0, 4'd4);
    repeat (WINDOW + 5) @(negedge clk);
    chk("R6 window expiry", 32'(mode_state), 32'd5);
    wr(0, 20'h00000, 16'h0030);
    expect_out("R9 erasing ignores 30h", 4'd0, 4'd5);
    wr(0, 20'h00555, 16'h00AA); wr(0, 20'h002AA, 16'h0055); wr(0, 20'h00555, 16'h0090);
    expect_out("R9 erasing ignores autosel", 4'd0, 4'd5);

    // R10 suspend, program in suspend, resume
    wr(0, 20'h00000, 16'h00B0);
    expect_out("R9 suspend", 4'd6, 4'd6);
    wr(0, 20'h00000, 16'h00B0);
    expect_out("R10 second suspend ignored", 4'd0, 4'd6);
    wr(0, 20'h00000, 16'h00F0);
    expect_out("R10 reset stays suspended", 4'd1, 4'd6);
    wr(0, 20'h00555, 16'h00AA); wr(0, 20'h002AA, 16'h0055); wr(0, 20'h00555, 16'h00A0);
    wr(0, 20'h00010, 16'h0055);
    expect_out("R10 program in suspend", 4'd3, 4'd8);
    done_pulse(1'b0);
    chk("R10 back to suspended", 32'(mode_state), 32'd6);
    wr(0, 20'h00000, 16'h0030);
    expect_out("R10 resume", 4'd7, 4'd5);
    done_pulse(1'b0);
    chk("R8 erase done", 32'(mode_state), 32'd0);

    // R12 reset mid-sequence returns to position zero
    wr(0, 20'h00555, 16'h00AA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(0, 20'h002AA, 16'h0055);
    wr(0, 20'h00555, 16'h0090);
    expect_out("R12 reset clears position", 4'd0, 4'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule